// File: doc/BRIEF.md
# Row-Splitting Burst Scheduler for a Multibank DRAM Channel

This block sits between an address sequencer and one channel of a multibank DRAM. The sequencer hands it a burst: a start address, a word count and a direction. The block then emits an abstract command stream on one command port. It activates the rows it needs, issues one read or write command per word, and pulses a completion flag with the last word. When a burst runs off the end of a row, the block splits it into two sub-bursts. The address-to-bank mapping guarantees that the two pieces sit in different banks, so both rows are opened back to back before any data moves.

Rows stay open after a burst. A following single-row burst to the row that was used last goes straight to data. Any other burst first precharges all banks. A free-running refresh timer requests a four-command refresh. If the channel is idle, the refresh runs at once. If a burst is moving data, it is broken with a stop command, and a hold is raised to the data client. After the refresh, the remaining rows are re-opened and the transfer resumes where it stopped.

Top module: `burst_split_ctrl`

## Requirements
- R1: After reset, the command output is NOP (code 0), `req_ready` is 1, and `client_hold` and `burst_done` are 0.
- R2: A request is taken on a clock edge where `req_valid` is 1 and `req_ready` is 1. `req_ready` is 1 only when no burst, precharge, activate or refresh is in progress and no refresh is due. While it is 0, `req_valid` has no effect.
- R3: The address is {bank[18:13], row[12:5], column[4:0]}. A line is address[18:5]. The physical bank of a line is (bank field + row[5:0]) mod 64, and the physical row is the row field. The first activate (code 1) for a burst names the line of its first word.
- R4: `req_len` holds the word count minus one, so the last word is at start + `req_len` (modulo 2^19). If the last word is on a different line, a second activate follows in the very next cycle for that line, and it names a different physical bank.
- R5: Words go out one per cycle after the activates, as read (2) or write (3). Each command carries the physical bank, the physical row and the column of its word, and the addresses increase by one. `burst_done` is 1 together with the last word only.
- R6: A request whose words all lie on the line used last by the previous burst gets its first data command in the cycle after acceptance, with no precharge and no activate. This holds only while that row is still open.
- R7: Any other request that arrives while rows are open gets one precharge-all (4) in the cycle after acceptance. The activates follow that precharge.
- R8: The refresh timer starts at REF_PERIOD and counts down once per clock to zero. A refresh is due at zero. The timer is reloaded with REF_PERIOD in the first cycle of the refresh commands.
- R9: A refresh that is due while idle produces REF_BURSTS consecutive refresh commands (5). If rows are open, one precharge-all comes first. The block then returns to idle with no rows open.
- R10: A refresh that is due during a data cycle that is not the last word produces, from the next cycle: stop (6), precharge-all, REF_BURSTS refresh commands, the activates for the remaining words, and then those words. `client_hold` is 1 from the stop command up to the first resumed word, and it is 0 from that word on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_addr | input | 19 | Start address {bank, row, column} |
| req_len | input | 5 | Word count minus one |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_ready | output | 1 | Request can be taken this cycle |
| cmd_op | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE-all, 5 REF, 6 STOP |
| cmd_bank | output | 6 | Physical bank for ACT/RD/WR, else 0 |
| cmd_row | output | 8 | Row for ACT/RD/WR, else 0 |
| cmd_col | output | 5 | Column for RD/WR, else 0 |
| burst_done | output | 1 | Last word of the burst is issued this cycle |
| client_hold | output | 1 | Data client must pause (burst pre-empted by refresh) |

## Verification
Every command is a Moore output of the registered state. The result of an accepted request therefore appears one cycle after the accepting edge:
- a precharge when the rows must change,
- an activate when no row is open,
- data at once on a row hit.

A due refresh is acted on in the cycle after the timer reads zero. That first action is either the stop or the precharge or refresh of the idle path. The bench keeps a queue of expected commands that it extends on acceptance and rewrites when a pre-emption occurs. It compares the whole port state against the queue head at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_ACT  = 3'd1,
      OP_RD   = 3'd2,
      OP_WR   = 3'd3,
      OP_PRE  = 3'd4,
      OP_REF  = 3'd5,
      OP_STOP = 3'd6
   } bcu_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT1,
      ST_ACT2,
      ST_XFER,
      ST_STOP,
      ST_REF
   } bcu_state_e;
endpackage

// File: rtl/bcu_addr_map.sv
// Maps a line index {bank field, row field} to a physical bank and row.
// Rotating the bank by the low row bits keeps adjacent lines in distinct banks.
module bcu_addr_map #(
   parameter int BANK_W = 6,
   parameter int ROW_W  = 8
) (
   input  logic [BANK_W+ROW_W-1:0] line,
   output logic [BANK_W-1:0]       phys_bank,
   output logic [ROW_W-1:0]        phys_row
);
   localparam int LINE_W = BANK_W + ROW_W;

   initial begin
      assert (BANK_W >= 1 && ROW_W >= 1)
         else $error("bcu_addr_map: field widths must be positive");
   end

   assign phys_row = line[ROW_W-1:0];

   generate
      if (ROW_W >= BANK_W) begin : g_fold
         assign phys_bank = line[LINE_W-1:ROW_W] + line[BANK_W-1:0];
      end else begin : g_ext
         assign phys_bank = line[LINE_W-1:ROW_W] + BANK_W'(line[ROW_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/bcu_refresh_timer.sv
module bcu_refresh_timer #(
   parameter int PERIOD = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   output logic due
);
   localparam int CW = $clog2(PERIOD + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (PERIOD >= 1) else $error("bcu_refresh_timer: PERIOD must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= CW'(PERIOD);
      else if (reload)            cnt_q <= CW'(PERIOD);
      else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
   end

   assign due = (cnt_q == '0);

   // R8
   ref_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !reload) |=> due);
   // R8
   ref_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> !due);
endmodule

// File: rtl/bcu_word_track.sv
// Holds the current word address and the words left; derives the line span.
module bcu_word_track #(
   parameter int BANK_W = 6,
   parameter int ROW_W  = 8,
   parameter int COL_W  = 5,
   parameter int LEN_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [BANK_W+ROW_W+COL_W-1:0] load_addr,
   input  logic [LEN_W-1:0]        load_len,
   input  logic                    adv,
   output logic [BANK_W+ROW_W-1:0] cur_line,
   output logic [COL_W-1:0]        cur_col,
   output logic [BANK_W+ROW_W-1:0] last_line,
   output logic                    split,
   output logic                    rem_one
);
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int LINE_W = BANK_W + ROW_W;
   localparam int RW     = LEN_W + 1;
   localparam int SW     = COL_W + 2;

   logic [ADDR_W-1:0] cur_q;
   logic [RW-1:0]     rem_q;

   initial begin
      assert (LEN_W <= COL_W) else $error("bcu_word_track: a burst may span at most two lines");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         rem_q <= '0;
      end else if (load) begin
         cur_q <= load_addr;
         rem_q <= RW'(load_len) + 1'b1;
      end else if (adv) begin
         cur_q <= cur_q + 1'b1;
         rem_q <= rem_q - 1'b1;
      end
   end

   assign cur_line  = cur_q[ADDR_W-1:COL_W];
   assign cur_col   = cur_q[COL_W-1:0];
   assign split     = (SW'(cur_q[COL_W-1:0]) + SW'(rem_q)) > SW'(2**COL_W);
   assign last_line = cur_line + LINE_W'(split);
   assign rem_one   = (rem_q == RW'(1));
endmodule

// File: rtl/burst_split_ctrl.sv
module burst_split_ctrl
   import bcu_pkg::*;
#(
   parameter int BANK_W     = 6,
   parameter int ROW_W      = 8,
   parameter int COL_W      = 5,
   parameter int LEN_W      = 5,
   parameter int REF_PERIOD = 400,
   parameter int REF_BURSTS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
   input  logic [LEN_W-1:0]              req_len,
   input  logic                          req_write,
   output logic                          req_ready,
   output logic [2:0]                    cmd_op,
   output logic [BANK_W-1:0]             cmd_bank,
   output logic [ROW_W-1:0]              cmd_row,
   output logic [COL_W-1:0]              cmd_col,
   output logic                          burst_done,
   output logic                          client_hold
);
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int LINE_W = BANK_W + ROW_W;
   localparam int RI_W   = (REF_BURSTS > 1) ? $clog2(REF_BURSTS) : 1;

   initial begin
      assert (REF_BURSTS >= 1) else $error("burst_split_ctrl: REF_BURSTS must be at least 1");
      assert (REF_PERIOD > REF_BURSTS) else $error("burst_split_ctrl: refresh period too short");
   end

   bcu_state_e        state_q, state_d;
   logic              pre_ref_q, pre_ref_d;
   logic              resume_q, resume_d;
   logic              open_q, open_d;
   logic [LINE_W-1:0] open_line_q, open_line_d;
   logic [RI_W-1:0]   ref_i_q, ref_i_d;
   logic              wr_q;

   logic              ref_due, ref_reload, accept, req_single, req_hit;
   logic [LINE_W-1:0] req_line, cur_line, last_line;
   logic [COL_W-1:0]  cur_col;
   logic              split, rem_one;
   logic [LINE_W-1:0] map_line [2];
   logic [BANK_W-1:0] map_bank [2];
   logic [ROW_W-1:0]  map_row  [2];
   bcu_op_e           op;

   bcu_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
      .clk(clk), .rst_n(rst_n), .reload(ref_reload), .due(ref_due)
   );

   bcu_word_track #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W)) u_track (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_addr(req_addr), .load_len(req_len),
      .adv(state_q == ST_XFER), .cur_line(cur_line), .cur_col(cur_col),
      .last_line(last_line), .split(split), .rem_one(rem_one)
   );

   assign map_line[0] = cur_line;
   assign map_line[1] = last_line;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_map
         bcu_addr_map #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_map (
            .line(map_line[g]), .phys_bank(map_bank[g]), .phys_row(map_row[g])
         );
      end
   endgenerate

   assign req_line   = req_addr[ADDR_W-1:COL_W];
   assign req_single = ({1'b0, req_addr[COL_W-1:0]} + (COL_W+1)'(req_len)) <= (COL_W+1)'(2**COL_W - 1);
   assign req_hit    = open_q && req_single && (req_line == open_line_q);
   assign req_ready  = (state_q == ST_IDLE) && !ref_due;
   assign accept     = req_ready && req_valid;
   assign ref_reload = (state_q == ST_REF) && (ref_i_q == '0);

   always_comb begin
      state_d     = state_q;
      pre_ref_d   = pre_ref_q;
      resume_d    = resume_q;
      open_d      = open_q;
      open_line_d = open_line_q;
      ref_i_d     = ref_i_q;
      unique case (state_q)
         ST_IDLE: begin
            if (ref_due) begin
               pre_ref_d = 1'b1;
               state_d   = open_q ? ST_PRE : ST_REF;
            end else if (req_valid) begin
               pre_ref_d = 1'b0;
               if (req_hit)     state_d = ST_XFER;
               else if (open_q) state_d = ST_PRE;
               else             state_d = ST_ACT1;
            end
         end
         ST_PRE: begin
            open_d  = 1'b0;
            state_d = pre_ref_q ? ST_REF : ST_ACT1;
         end
         ST_ACT1: begin
            if (split) state_d = ST_ACT2;
            else begin
               state_d     = ST_XFER;
               resume_d    = 1'b0;
               open_d      = 1'b1;
               open_line_d = last_line;
            end
         end
         ST_ACT2: begin
            state_d     = ST_XFER;
            resume_d    = 1'b0;
            open_d      = 1'b1;
            open_line_d = last_line;
         end
         ST_XFER: begin
            if (rem_one) state_d = ST_IDLE;
            else if (ref_due) begin
               state_d  = ST_STOP;
               resume_d = 1'b1;
            end
         end
         ST_STOP: begin
            pre_ref_d = 1'b1;
            state_d   = ST_PRE;
         end
         ST_REF: begin
            if (ref_i_q == RI_W'(REF_BURSTS - 1)) begin
               ref_i_d = '0;
               state_d = resume_q ? ST_ACT1 : ST_IDLE;
            end else begin
               ref_i_d = ref_i_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pre_ref_q   <= 1'b0;
         resume_q    <= 1'b0;
         open_q      <= 1'b0;
         open_line_q <= '0;
         ref_i_q     <= '0;
         wr_q        <= 1'b0;
      end else begin
         state_q     <= state_d;
         pre_ref_q   <= pre_ref_d;
         resume_q    <= resume_d;
         open_q      <= open_d;
         open_line_q <= open_line_d;
         ref_i_q     <= ref_i_d;
         if (accept) wr_q <= req_write;
      end
   end

   always_comb begin
      op       = OP_NOP;
      cmd_bank = '0;
      cmd_row  = '0;
      cmd_col  = '0;
      unique case (state_q)
         ST_PRE:  op = OP_PRE;
         ST_STOP: op = OP_STOP;
         ST_REF:  op = OP_REF;
         ST_ACT1: begin
            op = OP_ACT; cmd_bank = map_bank[0]; cmd_row = map_row[0];
         end
         ST_ACT2: begin
            op = OP_ACT; cmd_bank = map_bank[1]; cmd_row = map_row[1];
         end
         ST_XFER: begin
            op = wr_q ? OP_WR : OP_RD;
            cmd_bank = map_bank[0]; cmd_row = map_row[0]; cmd_col = cur_col;
         end
         default: op = OP_NOP;
      endcase
   end

   assign cmd_op      = op;
   assign burst_done  = (state_q == ST_XFER) && rem_one;
   assign client_hold = resume_q;

   // R4
   act_pair_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd1 && $past(cmd_op) == 3'd1) |-> (cmd_bank != $past(cmd_bank)));
   // R10
   stop_then_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd6) |=> (cmd_op == 3'd4));
   // R2
   ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cmd_op == 3'd0));
   // R10
   hold_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      client_hold |-> (cmd_op != 3'd2 && cmd_op != 3'd3));
   // R5
   done_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (cmd_op == 3'd2 || cmd_op == 3'd3));
endmodule

// File: tb/tb_burst_split_ctrl.sv
module tb_burst_split_ctrl;
   localparam int PERIOD = 60;
   localparam int NREF   = 4;
   localparam int AMASK  = 'h7FFFF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [18:0] req_addr;
   logic [4:0]  req_len;
   logic        req_write;
   logic        req_ready;
   logic [2:0]  cmd_op;
   logic [5:0]  cmd_bank;
   logic [7:0]  cmd_row;
   logic [4:0]  cmd_col;
   logic        burst_done;
   logic        client_hold;

   always #5 clk = ~clk;

   burst_split_ctrl #(.REF_PERIOD(PERIOD), .REF_BURSTS(NREF)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .req_write(req_write), .req_ready(req_ready),
      .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .burst_done(burst_done), .client_hold(client_hold)
   );

   typedef struct {
      int    op; int bank; int row; int col; int addr;
      bit    hold; bit done; bit first_ref;
      string tag;
   } item_t;

   item_t q[$];
   int    total = 0, fails = 0, rc;
   bit    open_rows = 0, finished = 0;
   int    open_line = 0;
   logic [15:0] lf = 16'hACE1;

   function automatic int line_of(int a); return (a & AMASK) >> 5; endfunction
   function automatic int pbank(int ln); return ((ln >> 8) + (ln & 63)) & 63; endfunction
   function automatic int prow(int ln); return ln & 255; endfunction

   function automatic item_t mk(int op, int ln, int col, string tag, bit hold);
      item_t it;
      it.op = op; it.bank = 0; it.row = 0; it.col = 0; it.addr = 0;
      it.hold = hold; it.done = 0; it.first_ref = 0; it.tag = tag;
      if (op == 1 || op == 2 || op == 3) begin it.bank = pbank(ln); it.row = prow(ln); end
      if (op == 2 || op == 3) it.col = col;
      return it;
   endfunction

   task automatic push_refresh(string tag, bit hold);
      for (int i = 0; i < NREF; i++) begin
         item_t it = mk(5, 0, 0, (i == 0) ? "R8" : tag, hold);
         it.first_ref = (i == 0);
         q.push_back(it);
      end
   endtask

   function automatic void step_lfsr();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endfunction

   // current pending request
   bit have_req = 0;
   int r_addr, r_len, r_wr, gap = 0, nreq = 0, prev_line = 0;

   task automatic next_request();
      int ex_a[7] = '{'h00040, 'h00048, 'h0005C, 'h00060, 'h0BFFE, 'h7FFFE, 'h12345};
      int ex_l[7] = '{2, 3, 6, 0, 4, 3, 31};
      if (nreq < 7) begin
         r_addr = ex_a[nreq]; r_len = ex_l[nreq]; r_wr = nreq % 2;
      end else begin
         step_lfsr(); r_addr = {lf[2:0], 16'h0};
         step_lfsr(); r_addr = r_addr | lf;
         step_lfsr();
         if (lf[1:0] == 2'b00) r_addr = (prev_line << 5) | (lf[8:4]);
         r_len = lf[15:11]; r_wr = lf[3];
      end
      r_addr = r_addr & AMASK;
      have_req = 1; nreq++;
   endtask

   task automatic model_step(bit valid);
      if (q.size() == 0) begin
         if (rc == 0) begin
            if (open_rows) q.push_back(mk(4, 0, 0, "R9", 0));
            push_refresh("R9", 0);
            open_rows = 0;
         end else if (valid) begin
            int n = r_len + 1, last = (r_addr + r_len) & AMASK;
            bit single = (line_of(last) == line_of(r_addr));
            bit hit = open_rows && single && (line_of(r_addr) == open_line);
            if (!hit) begin
               if (open_rows) q.push_back(mk(4, 0, 0, "R7", 0));
               q.push_back(mk(1, line_of(r_addr), 0, "R3", 0));
               if (!single) q.push_back(mk(1, line_of(last), 0, "R4", 0));
            end
            for (int i = 0; i < n; i++) begin
               int a = (r_addr + i) & AMASK;
               item_t it = mk(r_wr ? 3 : 2, line_of(a), a & 31, hit ? "R6" : "R5", 0);
               it.addr = a; it.done = (i == n - 1);
               q.push_back(it);
            end
            open_rows = 1; open_line = line_of(last);
            prev_line = line_of(r_addr);
            have_req = 0;
            step_lfsr();
            gap = (lf[12:11] == 2'b00) ? 80 : 0;
         end
         if (rc > 0) rc--;
      end else begin
         item_t h = q.pop_front();
         if ((h.op == 2 || h.op == 3) && !h.done && rc == 0) begin
            item_t ins[$];
            int fl = line_of(q[0].addr), ll = line_of(q[q.size()-1].addr);
            ins.push_back(mk(6, 0, 0, "R10", 1));
            ins.push_back(mk(4, 0, 0, "R10", 1));
            for (int i = 0; i < NREF; i++) begin
               item_t it = mk(5, 0, 0, "R10", 1);
               it.first_ref = (i == 0);
               ins.push_back(it);
            end
            ins.push_back(mk(1, fl, 0, "R10", 1));
            if (ll != fl) ins.push_back(mk(1, ll, 0, "R10", 1));
            for (int i = ins.size() - 1; i >= 0; i--) q.push_front(ins[i]);
         end
         if (h.first_ref) rc = PERIOD;
         else if (rc > 0) rc--;
      end
   endtask

   task automatic compare(int cyc, bit is_reset);
      item_t e;
      bit e_ready = (q.size() == 0) && (rc != 0);
      string tag;
      if (q.size() == 0) e = mk(0, 0, 0, "R2", 0); else e = q[0];
      tag = is_reset ? "R1" : ((req_ready !== e_ready) ? "R2" : e.tag);
      total++;
      if (cmd_op !== 3'(e.op) || cmd_bank !== 6'(e.bank) || cmd_row !== 8'(e.row) ||
          cmd_col !== 5'(e.col) || client_hold !== e.hold || burst_done !== e.done ||
          req_ready !== e_ready) begin
         fails++;
         $display("FAIL %s cycle %0d: op=%0d bank=%0d row=%0d col=%0d hold=%0b done=%0b ready=%0b expected op=%0d bank=%0d row=%0d col=%0d hold=%0b done=%0b ready=%0b",
                  tag, cyc, cmd_op, cmd_bank, cmd_row, cmd_col, client_hold, burst_done, req_ready,
                  e.op, e.bank, e.row, e.col, e.hold, e.done, e_ready);
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0;
      repeat (4) @(negedge clk);
      rc = PERIOD;
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 5000; cyc++) begin
         bit v;
         if (cyc > 0) @(negedge clk);
         compare(cyc, cyc == 0);   // cycle 0: R1 reset state
         if (!have_req && gap == 0) next_request();
         v = have_req && (gap == 0);
         if (gap > 0) gap--;
         req_valid = v;
         req_addr  = 19'(r_addr);
         req_len   = 5'(r_len);
         req_write = r_wr[0];
         model_step(v);
      end
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         total++; fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule